// File: doc/BRIEF.md
# Scrambled Radio Packet Framer

This block assembles the transmit byte sequence for a 2.4 GHz GFSK link whose receivers expect a whitened address and payload protected by a 16-bit CRC. Software or a neighbouring controller first writes an address of 3 to 5 bytes and a payload of up to 25 bytes through a single byte-wide load port. It then pulses `start` together with the two lengths. The framer emits the frame one byte per handshake on a valid/ready stream.

The frame has four parts, in this order: a length byte, a fixed three-byte preamble, the body, and a CRC. The body is the whitened address followed by the whitened payload. The CRC is computed over the body as the body streams out, so the frame needs no pre-pass. The whitening table and the per-length CRC correction table are parameters, so one instance serves one link flavour with no run-time table storage.

Top module: `scr_framer`

## Requirements
- R1: While and right after reset, `tx_valid` and `done` are low, and no byte is offered until a `start` is accepted.
- R2: Each frame begins with a byte equal to (address length + payload length + 5), followed by 0x71, 0x0F and 0x55, in that order.
- R3: A `cfg_alen` above 5 is taken as 5, and one below 3 is taken as 3.
- R4: Address bytes go out starting with the last loaded byte. The byte at body position i (i from 0) is the address byte with index (alen−1−i), XORed with whitening entry i.
- R5: Payload byte k has its bit order reversed (bit 7 swaps with bit 0, and so on). It is then XORed with whitening entry (alen + k).
- R6: The CRC uses polynomial 0x1021, MSB first, with no reflection, and starts from 0xB5D2. It runs over every body byte as sent. It is then XORed with correction entry (alen − 3 + plen) and sent high byte first, low byte second.
- R7: A `cfg_plen` above 25 is taken as 25, so the body, CRC included, never exceeds 32 bytes. A payload length of 0 is legal.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R9: Loads and `start` pulses that arrive while a frame is in progress have no effect on that frame or on the stored address and payload.
- R10: `done` is a one-cycle pulse in the cycle after the final CRC byte is accepted. A frame holds exactly 4 + alen + plen + 2 bytes.
- R11: With `ld_we` high, `ld_sel`=0 writes address byte `ld_idx` (indices 0 to 4), and `ld_sel`=1 writes payload byte `ld_idx` (indices 0 to 24). Other indices are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load strobe |
| ld_sel | input | 1 | Load target: 0 address, 1 payload |
| ld_idx | input | 5 | Byte index within the chosen target |
| ld_data | input | 8 | Byte to store |
| start | input | 1 | Begin a frame with the given lengths |
| cfg_alen | input | 3 | Requested address length (clamped to 3..5) |
| cfg_plen | input | 5 | Requested payload length (clamped to 0..25) |
| tx_valid | output | 1 | Output byte is valid |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Sink accepts the byte |
| done | output | 1 | Frame finished pulse |

## Verification
The bench keeps the default sizes: an address of up to 5 bytes and a payload of up to 25 bytes. This makes the 32-byte body ceiling and both clamps reachable. It overrides both table parameters with its own patterns, in which every whitening entry and every correction entry differs from its neighbours. A byte taken from the wrong table slot, a wrong address order or a wrong correction index therefore shows up as a miscompare. Frames are driven at the shortest and longest lengths, with a stalling sink, and with loads and starts injected mid-frame.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int          TAB_CAP  = 64;
  localparam logic [15:0] CRC_SEED = 16'hB5D2;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [23:0] PREAMBLE = 24'h710F55;

  // default whitening table: 8-bit LFSR walk
  function automatic logic [TAB_CAP*8-1:0] scr_default();
    logic [TAB_CAP*8-1:0] t;
    logic [7:0] s;
    s = 8'hE3;
    for (int i = 0; i < TAB_CAP; i++) begin
      t[i*8 +: 8] = s;
      s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    end
    return t;
  endfunction

  // default CRC correction table: 16-bit LFSR walk
  function automatic logic [TAB_CAP*16-1:0] xor_default();
    logic [TAB_CAP*16-1:0] t;
    logic [15:0] s;
    s = 16'h9A3C;
    for (int i = 0; i < TAB_CAP; i++) begin
      t[i*16 +: 16] = s;
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    end
    return t;
  endfunction

  function automatic logic [7:0] bit_rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/sf_crc16.sv
module sf_crc16 #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic [15:0] crc_in,
  input  logic [7:0]  data,
  output logic [15:0] crc_out
);
  always_comb begin
    logic [15:0] c;
    c = crc_in;
    for (int b = 7; b >= 0; b--) begin
      if (c[15] ^ data[b]) c = {c[14:0], 1'b0} ^ POLY;
      else                 c = {c[14:0], 1'b0};
    end
    crc_out = c;
  end
endmodule

// File: rtl/sf_pld_ram.sv
module sf_pld_ram #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/scr_framer.sv
module scr_framer
  import sf_pkg::*;
#(
  parameter int ADDR_MIN = 3,
  parameter int ADDR_MAX = 5,
  parameter int PLD_MAX  = 25,
  parameter logic [TAB_CAP*8-1:0]  SCR_TAB = scr_default(),
  parameter logic [TAB_CAP*16-1:0] XOR_TAB = xor_default(),
  localparam int AL_W  = $clog2(ADDR_MAX + 1),
  localparam int PL_W  = $clog2(PLD_MAX + 1),
  localparam int IDX_W = $clog2(PLD_MAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic             ld_sel,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic             start,
  input  logic [AL_W-1:0]  cfg_alen,
  input  logic [PL_W-1:0]  cfg_plen,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  output logic             done
);
  localparam int POS_W = $clog2(ADDR_MAX + PLD_MAX + 7);

  logic             busy;
  logic [POS_W-1:0] pos;
  logic [AL_W-1:0]  alen_q, alen_cl;
  logic [PL_W-1:0]  plen_q, plen_cl;
  logic [15:0]      crc_q, crc_nx, crc_fin;
  logic             out_valid, out_last, done_q;
  logic [7:0]       out_data, nb, rd_q;
  logic [7:0]       addr_r [ADDR_MAX];

  // ---------------- load side ----------------
  logic addr_we, pld_we;
  assign addr_we = ld_we && !ld_sel && !busy && (ld_idx < IDX_W'(ADDR_MAX));
  assign pld_we  = ld_we &&  ld_sel && !busy && (ld_idx < IDX_W'(PLD_MAX));

  for (genvar g = 0; g < ADDR_MAX; g++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst)                                 addr_r[g] <= '0;
      else if (addr_we && ld_idx == IDX_W'(g)) addr_r[g] <= ld_data;
    end
  end

  // ---------------- length clamps ----------------
  always_comb begin
    if (cfg_alen > AL_W'(ADDR_MAX))      alen_cl = AL_W'(ADDR_MAX);
    else if (cfg_alen < AL_W'(ADDR_MIN)) alen_cl = AL_W'(ADDR_MIN);
    else                                 alen_cl = cfg_alen;
    plen_cl = (cfg_plen > PL_W'(PLD_MAX)) ? PL_W'(PLD_MAX) : cfg_plen;
  end

  // ---------------- frame geometry ----------------
  logic [POS_W-1:0] pay_start, crc_pos, last_pos, ai, pnext, xi;
  logic             can_emit, in_addr, in_pld;
  assign pay_start = POS_W'(4) + POS_W'(alen_q);
  assign crc_pos   = pay_start + POS_W'(plen_q);
  assign last_pos  = crc_pos + POS_W'(1);
  assign ai        = pos - POS_W'(4);
  assign in_addr   = (pos >= POS_W'(4)) && (pos < pay_start);
  assign in_pld    = (pos >= pay_start) && (pos < crc_pos);
  assign can_emit  = busy && (pos <= last_pos) && (!out_valid || tx_ready);
  assign pnext     = can_emit ? pos + POS_W'(1) : pos;
  assign xi        = POS_W'(alen_q) + POS_W'(plen_q) - POS_W'(ADDR_MIN);
  assign crc_fin   = crc_q ^ XOR_TAB[{xi, 4'b0000} +: 16];

  // payload store, read one position ahead so data is ready when pos arrives
  logic [IDX_W-1:0] ridx;
  assign ridx = IDX_W'(pnext - pay_start);

  sf_pld_ram #(.DW(8), .AW(IDX_W)) u_ram (
    .clk   (clk),
    .we    (pld_we),
    .waddr (ld_idx),
    .wdata (ld_data),
    .raddr (ridx),
    .rdata (rd_q)
  );

  // ---------------- byte select ----------------
  logic [AL_W-1:0] asel;
  logic [7:0]      scr_b;
  assign asel  = AL_W'(POS_W'(alen_q) - POS_W'(1) - ai);
  assign scr_b = SCR_TAB[{ai, 3'b000} +: 8];

  always_comb begin
    nb = 8'h00;
    if (pos == '0)                nb = 8'(alen_q) + 8'(plen_q) + 8'd5;
    else if (pos == POS_W'(1))    nb = PREAMBLE[23:16];
    else if (pos == POS_W'(2))    nb = PREAMBLE[15:8];
    else if (pos == POS_W'(3))    nb = PREAMBLE[7:0];
    else if (in_addr)             nb = addr_r[asel] ^ scr_b;
    else if (in_pld)              nb = bit_rev8(rd_q) ^ scr_b;
    else if (pos == crc_pos)      nb = crc_fin[15:8];
    else                          nb = crc_fin[7:0];
  end

  sf_crc16 #(.POLY(CRC_POLY)) u_crc (
    .crc_in  (crc_q),
    .data    (nb),
    .crc_out (crc_nx)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pos       <= '0;
      alen_q    <= AL_W'(ADDR_MIN);
      plen_q    <= '0;
      crc_q     <= CRC_SEED;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= out_valid && tx_ready && out_last;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          pos    <= '0;
          alen_q <= alen_cl;
          plen_q <= plen_cl;
          crc_q  <= CRC_SEED;
        end
      end else if (can_emit) begin
        out_valid <= 1'b1;
        out_data  <= nb;
        out_last  <= (pos == last_pos);
        pos       <= pos + POS_W'(1);
        if (in_addr || in_pld) crc_q <= crc_nx;
      end else if (out_valid && tx_ready) begin
        out_valid <= 1'b0;
        if (out_last) busy <= 1'b0;
      end
    end
  end

  assign tx_valid = out_valid;
  assign tx_data  = out_data;
  assign done     = done_q;
endmodule

// File: rtl/sf_checker.sv
module sf_checker (
  input logic       clk,
  input logic       rst,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       done
);
  // R1: outputs quiet in the cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!tx_valid && !done));

  // R8: offered byte held while the sink stalls
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R10: completion is a single-cycle pulse
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: completion follows an accepted byte
  assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(tx_valid && tx_ready));

  // R10: nothing is offered in the completion cycle
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !tx_valid);
endmodule

bind scr_framer sf_checker u_sf_checker (.*);

// File: tb/scr_framer_test.sv
`timescale 1ns/1ps
module scr_framer_test;
  import sf_pkg::*;

  function automatic logic [TAB_CAP*8-1:0] mk_scr();
    logic [TAB_CAP*8-1:0] t;
    for (int i = 0; i < TAB_CAP; i++) t[i*8 +: 8] = 8'((i * 73 + 29) % 256);
    return t;
  endfunction
  function automatic logic [TAB_CAP*16-1:0] mk_xor();
    logic [TAB_CAP*16-1:0] t;
    for (int i = 0; i < TAB_CAP; i++) t[i*16 +: 16] = 16'(i * 7995) ^ 16'hC0DE;
    return t;
  endfunction
  localparam logic [TAB_CAP*8-1:0]  TB_SCR = mk_scr();
  localparam logic [TAB_CAP*16-1:0] TB_XOR = mk_xor();

  logic clk = 1'b0, rst = 1'b1;
  logic ld_we = 0, ld_sel = 0, start = 0, tx_ready = 1;
  logic [4:0] ld_idx = '0, cfg_plen = '0;
  logic [2:0] cfg_alen = '0;
  logic [7:0] ld_data = '0, tx_data;
  logic tx_valid, done;

  always #2 clk = ~clk;

  scr_framer #(.SCR_TAB(TB_SCR), .XOR_TAB(TB_XOR)) uut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .ld_data(ld_data), .start(start), .cfg_alen(cfg_alen), .cfg_plen(cfg_plen),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_addr [5];
  logic [7:0] m_pld  [25];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  int e_al, e_pl;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic load_byte(input bit sel, input int idx, input logic [7:0] d, input bit mirror);
    @(negedge clk);
    ld_we = 1; ld_sel = sel; ld_idx = 5'(idx); ld_data = d;
    @(negedge clk);
    ld_we = 0;
    if (mirror) begin
      if (!sel) m_addr[idx] = d; else m_pld[idx] = d;
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
  endfunction

  task automatic build_expected(input int ac, input int pc);
    logic [15:0] crc;
    logic [7:0]  b;
    logic [7:0]  body [$];
    e_al = (ac > 5) ? 5 : (ac < 3) ? 3 : ac;
    e_pl = (pc > 25) ? 25 : pc;
    for (int i = 0; i < e_al; i++) body.push_back(m_addr[e_al-1-i] ^ TB_SCR[i*8 +: 8]);
    for (int k = 0; k < e_pl; k++) body.push_back(rev8(m_pld[k]) ^ TB_SCR[(e_al+k)*8 +: 8]);
    crc = 16'hB5D2;
    foreach (body[j]) begin
      b = body[j];
      for (int t = 7; t >= 0; t--) begin
        if (crc[15] ^ b[t]) crc = {crc[14:0], 1'b0} ^ 16'h1021;
        else                crc = {crc[14:0], 1'b0};
      end
    end
    crc = crc ^ TB_XOR[(e_al - 3 + e_pl)*16 +: 16];
    body.push_back(crc[15:8]);
    body.push_back(crc[7:0]);
    exp_q.delete();
    exp_q.push_back(8'(body.size() + 3));
    exp_q.push_back(8'h71); exp_q.push_back(8'h0F); exp_q.push_back(8'h55);
    foreach (body[j]) exp_q.push_back(body[j]);
  endtask

  task automatic run_frame(input int ac, input int pc, input bit stall, input string tag);
    bit prev_stall = 0, seen = 0, r;
    logic [7:0] prev_data = 0;
    int cyc = 0;
    string rq;
    build_expected(ac, pc);
    got_q.delete();
    @(negedge clk);
    start = 1; cfg_alen = 3'(ac); cfg_plen = 5'(pc);
    @(negedge clk);
    start = 0;
    while (!seen && cyc < 400) begin
      r = stall ? ((cyc % 3) != 1 && (cyc % 11) != 5) : 1'b1;
      if (prev_stall)
        check(tx_valid && tx_data == prev_data, {tag, " R8 hold"}, tx_data, prev_data);
      tx_ready = r;
      if (tx_valid && r) got_q.push_back(tx_data);
      prev_stall = tx_valid && !r;
      prev_data  = tx_data;
      if (done) seen = 1;
      @(negedge clk);
      cyc++;
    end
    tx_ready = 1;
    check(seen, {tag, " R10 done seen"}, seen, 1);
    check(got_q.size() == exp_q.size(), {tag, " R10 frame size"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      if (i < 4)                rq = "R2";
      else if (i < 4 + e_al)    rq = "R4";
      else if (i < 4 + e_al + e_pl) rq = "R5";
      else                      rq = "R6";
      check(got_q[i] === exp_q[i], $sformatf("%s %s byte %0d", tag, rq, i), got_q[i], exp_q[i]);
    end
    for (int i = 0; i < 3; i++) begin
      check(!done && !tx_valid, {tag, " R10 quiet after done"}, {done, tx_valid}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(!tx_valid && !done, "R1 in reset", {tx_valid, done}, 0);
    @(negedge clk); rst = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!tx_valid && !done, "R1 idle after reset", {tx_valid, done}, 0);
    end
  endtask

  task automatic t_fill();
    for (int i = 0; i < 5; i++)  load_byte(0, i, 8'(8'hA1 + i * 17), 1);
    for (int i = 0; i < 25; i++) load_byte(1, i, 8'(i * 29 + 3), 1);
    load_byte(0, 7, 8'hEE, 0);    // R11: out of range index ignored
    load_byte(1, 28, 8'hEE, 0);   // R11: out of range index ignored
  endtask

  task automatic t_basic();   run_frame(5, 10, 0, "basic R11"); run_frame(4, 1, 0, "alen4"); endtask
  task automatic t_min();     run_frame(3, 0, 0, "min R7 empty payload"); endtask
  task automatic t_clamp_a(); run_frame(7, 6, 0, "R3 clamp high"); run_frame(1, 6, 0, "R3 clamp low");
                              run_frame(0, 2, 0, "R3 clamp zero"); endtask
  task automatic t_max();     run_frame(5, 25, 0, "R7 max body"); run_frame(5, 31, 0, "R7 clamp plen"); endtask
  task automatic t_stall();   run_frame(4, 7, 1, "R8 stall"); run_frame(5, 25, 1, "R8 stall max"); endtask

  task automatic t_busy();
    fork
      run_frame(5, 12, 1, "R9 busy");
      begin
        repeat (6) @(negedge clk);
        ld_we = 1; ld_sel = 0; ld_idx = 5'd1; ld_data = 8'h00;
        @(negedge clk);
        ld_sel = 1; ld_idx = 5'd2; ld_data = 8'hFF;
        @(negedge clk);
        ld_we = 0;
        repeat (3) @(negedge clk);
        start = 1; cfg_alen = 3'd3; cfg_plen = 5'd1;
        @(negedge clk);
        start = 0;
      end
    join
    run_frame(5, 12, 0, "R9 store unchanged");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_basic();
    t_min();
    t_clamp_a();
    t_max();
    t_stall();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule